// File: doc/BRIEF.md
# Streaming Word-Window Transfer Buffer

This block holds the 512-byte staging buffer that sits between a host register port and a serial flash sequencer. The host never sees the buffer as a memory map. It programs a control register with a transfer direction, an optional post-increment flag and a starting word index. It then touches one 32-bit data window over and over, moving a whole word on each access. If the last word of a transfer is only partly used, it still moves as a full word and only its low-order bytes count.

The sequencer has its own byte-wide port. It walks the same storage one byte at a time from a start offset that software programs through the host port. Software normally sets that offset to zero before each transfer. While the sequencer reports that it is moving data, host accesses to the data window are held off. This way a word is never split between the two sides. Register accesses go ahead at all times.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset, reading the control register (host address 0) and the offset register (host address 2) both return 0.
- R2: A host write to the control register stores the direction flag from bit 31, the post-increment flag from bit 30 and a 7-bit word index from bits 6:0. Bit 7 of the index field is ignored. A control read returns {direction, increment, 23 zeros, index}.
- R3: A host write to the data window (host address 1) stores the full word at the current index only when the direction flag is 1. With the flag at 0 the write leaves the buffer unchanged. A data-window read always returns the word at the current index.
- R4: An accepted data-window access advances the word index by one when the increment flag is 1. It leaves the index unchanged when the flag is 0.
- R5: Advancing from word index 127 gives index 0.
- R6: Buffer byte b is held in word b/4, bits 8*(b mod 4)+7 down to 8*(b mod 4), so the bytes are in little-endian order.
- R7: A one-cycle start pulse loads the sequencer byte pointer from the offset register. Each sequencer byte access advances the pointer by one, and 511 wraps to 0.
- R8: A sequencer byte write stores one byte at the pointer and leaves the other three bytes of that word unchanged. The read byte output always shows the byte at the pointer.
- R9: While the sequencer busy or byte-request input is high, a data-window access gets no acknowledge and changes neither the buffer nor the word index. Control and offset accesses are still acknowledged.
- R10: The offset register (host address 2) holds 9 bits, written from bits 8:0 and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host access request, held until acknowledged |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 2 | Host register select: 0 control, 1 data window, 2 offset, 3 unused |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Host access accepted in this cycle |
| h_rdata | output | 32 | Host read data, valid while h_ack is high |
| s_busy | input | 1 | Sequencer transfer in progress |
| s_start | input | 1 | Load the sequencer byte pointer from the offset register |
| s_req | input | 1 | Sequencer byte access; the pointer advances at the clock edge |
| s_we | input | 1 | Sequencer byte access is a write |
| s_wdata | input | 8 | Sequencer write byte |
| s_rdata | output | 8 | Byte at the sequencer pointer |

## Verification
The hardest case to reach is a host data-window access that collides with a sequencer transfer. In that case the host request must stall without disturbing the word index, while a register access made in the same stretch must still be acknowledged. The stimulus first sets up a read with post-increment, then raises the busy input and writes bytes through the sequencer. During that time it tries a data read and a control read. It then confirms, through a control read, that the index did not move. It also reads the merged word to check both the byte lanes and the stall. The byte-pointer wrap is reached by programming offset 511 and stepping past it.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

  typedef enum logic [1:0] {
    HREG_CTRL = 2'd0,
    HREG_DATA = 2'd1,
    HREG_OFFS = 2'd2,
    HREG_NONE = 2'd3
  } hreg_e;

  localparam int unsigned DIR_BIT   = 31;
  localparam int unsigned INC_BIT   = 30;
  localparam int unsigned LANE_BITS = 8;

  // Next value of a pointer that wraps at span.
  function automatic int unsigned step_wrap(int unsigned cur, int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction

  // Bit offset of a byte within its 32-bit word (little-endian).
  function automatic int unsigned lane_shift(int unsigned byte_addr);
    return (byte_addr % 4) * LANE_BITS;
  endfunction

endpackage

// File: rtl/xbuf_host_regs.sv
module xbuf_host_regs #(
  parameter int WORDS  = 128,
  parameter int WPTR_W = 7,
  parameter int BPTR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [1:0]        h_addr,
  input  logic [31:0]       h_wdata,
  input  logic              stall,
  output logic              h_ack,
  output logic              data_sel,
  output logic              word_we,
  output logic [WPTR_W-1:0] wptr,
  output logic [BPTR_W-1:0] ofs,
  output logic [31:0]       reg_rdata
);
  import xbuf_pkg::*;

  localparam logic [WPTR_W-1:0] WPTR_MAX = WPTR_W'(WORDS - 1);

  logic dir_q, inc_q;
  logic is_data, data_go, advance, ctrl_wr, ofs_wr;

  assign is_data  = h_req && (hreg_e'(h_addr) == HREG_DATA);
  assign data_go  = is_data && !stall;
  assign h_ack    = h_req && !(is_data && stall);
  assign data_sel = (hreg_e'(h_addr) == HREG_DATA);
  assign word_we  = data_go && h_we && dir_q;
  assign advance  = data_go && inc_q;
  assign ctrl_wr  = h_req && h_we && (hreg_e'(h_addr) == HREG_CTRL);
  assign ofs_wr   = h_req && h_we && (hreg_e'(h_addr) == HREG_OFFS);

  logic unused_wbits;
  assign unused_wbits = ^h_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      inc_q <= 1'b0;
      wptr  <= '0;
      ofs   <= '0;
    end else begin
      if (ctrl_wr) begin
        dir_q <= h_wdata[DIR_BIT];
        inc_q <= h_wdata[INC_BIT];
        wptr  <= h_wdata[WPTR_W-1:0];
      end else if (advance) begin
        wptr <= WPTR_W'(step_wrap(32'(wptr), WORDS));
      end
      if (ofs_wr) ofs <= h_wdata[BPTR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (hreg_e'(h_addr))
      HREG_CTRL: begin
        reg_rdata[DIR_BIT]      = dir_q;
        reg_rdata[INC_BIT]      = inc_q;
        reg_rdata[WPTR_W-1:0]   = wptr;
      end
      HREG_OFFS: reg_rdata[BPTR_W-1:0] = ofs;
      default:   reg_rdata = '0;
    endcase
  end

  // R9: a stalled data access leaves the word index alone
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && stall) |=> $stable(wptr));

  // R4: without post-increment the index holds
  p_no_inc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && !inc_q) |=> $stable(wptr));

  // R4: with post-increment the index steps by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wptr != WPTR_MAX) |=> (wptr == WPTR_W'($past(wptr) + 1'b1)));

  // R5: last word wraps to word zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wptr == WPTR_MAX) |=> (wptr == '0));

endmodule

// File: rtl/xbuf_seq_port.sv
module xbuf_seq_port #(
  parameter int BUF_BYTES = 512,
  parameter int BPTR_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_start,
  input  logic              s_req,
  input  logic              s_we,
  input  logic [BPTR_W-1:0] ofs,
  output logic [BPTR_W-1:0] bptr,
  output logic              byte_we
);
  import xbuf_pkg::*;

  localparam logic [BPTR_W-1:0] BPTR_MAX = BPTR_W'(BUF_BYTES - 1);

  assign byte_we = s_req && s_we && !s_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bptr <= '0;
    else if (s_start) bptr <= ofs;
    else if (s_req)   bptr <= BPTR_W'(step_wrap(32'(bptr), BUF_BYTES));
  end

  // R7: start pulse loads the programmed offset
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_start |=> (bptr == $past(ofs)));

  // R7: byte pointer wraps from the last byte to zero
  p_seq_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && !s_start && bptr == BPTR_MAX) |=> (bptr == '0));

endmodule

// File: rtl/xbuf_store.sv
module xbuf_store #(
  parameter int WORDS  = 128,
  parameter int WPTR_W = 7,
  parameter int BPTR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_we,
  input  logic [WPTR_W-1:0] w_addr,
  input  logic [31:0]       w_wdata,
  output logic [31:0]       w_rdata,
  input  logic              b_we,
  input  logic [BPTR_W-1:0] b_addr,
  input  logic [7:0]        b_wdata,
  output logic [7:0]        b_rdata
);
  import xbuf_pkg::*;

  logic [31:0]       mem [WORDS];
  logic [WPTR_W-1:0] b_word;
  logic [4:0]        b_shift;

  assign b_word  = b_addr[BPTR_W-1:2];
  assign b_shift = 5'(lane_shift(32'(b_addr)));

  always_ff @(posedge clk) begin
    if (w_we)      mem[w_addr] <= w_wdata;
    else if (b_we) mem[b_word][b_shift +: 8] <= b_wdata;
  end

  assign w_rdata = mem[w_addr];
  assign b_rdata = mem[b_word][b_shift +: 8];

  // R9: host word writes and sequencer byte writes never coincide
  p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_we && b_we));

endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port #(
  parameter int BUF_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_req,
  input  logic        h_we,
  input  logic [1:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic        h_ack,
  output logic [31:0] h_rdata,
  input  logic        s_busy,
  input  logic        s_start,
  input  logic        s_req,
  input  logic        s_we,
  input  logic [7:0]  s_wdata,
  output logic [7:0]  s_rdata
);
  localparam int WORDS  = BUF_BYTES / 4;
  localparam int WPTR_W = $clog2(WORDS);
  localparam int BPTR_W = $clog2(BUF_BYTES);

  logic              stall, data_sel, word_we, byte_we;
  logic [WPTR_W-1:0] wptr;
  logic [BPTR_W-1:0] ofs, bptr;
  logic [31:0]       reg_rdata, word_rdata;

  assign stall   = s_busy || s_req;
  assign h_rdata = data_sel ? word_rdata : reg_rdata;

  xbuf_host_regs #(.WORDS(WORDS), .WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .stall(stall), .h_ack(h_ack), .data_sel(data_sel),
    .word_we(word_we), .wptr(wptr), .ofs(ofs), .reg_rdata(reg_rdata)
  );

  xbuf_seq_port #(.BUF_BYTES(BUF_BYTES), .BPTR_W(BPTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .s_start(s_start), .s_req(s_req), .s_we(s_we),
    .ofs(ofs), .bptr(bptr), .byte_we(byte_we)
  );

  xbuf_store #(.WORDS(WORDS), .WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .w_we(word_we), .w_addr(wptr), .w_wdata(h_wdata), .w_rdata(word_rdata),
    .b_we(byte_we), .b_addr(bptr), .b_wdata(s_wdata), .b_rdata(s_rdata)
  );

endmodule

// File: tb/xfer_buf_port_test.sv
module xfer_buf_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [1:0]  h_addr = 2'd0;
  logic [31:0] h_wdata = '0;
  logic        h_ack;
  logic [31:0] h_rdata;
  logic        s_busy = 1'b0, s_start = 1'b0, s_req = 1'b0, s_we = 1'b0;
  logic [7:0]  s_wdata = '0;
  logic [7:0]  s_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xfer_buf_port uut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_ack(h_ack), .h_rdata(h_rdata), .s_busy(s_busy),
    .s_start(s_start), .s_req(s_req), .s_we(s_we), .s_wdata(s_wdata),
    .s_rdata(s_rdata)
  );

  // {req[4], we, addr[2], wdata[32], check, expected[32]}
  localparam int NV = 24;
  localparam logic [71:0] VEC [NV] = '{
    {4'd2,  1'b1, 2'd0, 32'hC000_0000, 1'b0, 32'h0},          // R2 write, auto, idx 0
    {4'd3,  1'b1, 2'd1, 32'h1122_3344, 1'b0, 32'h0},          // R3
    {4'd3,  1'b1, 2'd1, 32'hAABB_CCDD, 1'b0, 32'h0},          // R3
    {4'd4,  1'b0, 2'd0, 32'h0,         1'b1, 32'hC000_0002},  // R4 advanced twice
    {4'd2,  1'b1, 2'd0, 32'h4000_0000, 1'b0, 32'h0},          // R2 read, auto
    {4'd3,  1'b0, 2'd1, 32'h0,         1'b1, 32'h1122_3344},  // R3
    {4'd4,  1'b0, 2'd1, 32'h0,         1'b1, 32'hAABB_CCDD},  // R4
    {4'd2,  1'b0, 2'd0, 32'h0,         1'b1, 32'h4000_0002},  // R2 readback
    {4'd2,  1'b1, 2'd0, 32'h0000_0001, 1'b0, 32'h0},          // R2 idx 1, no auto
    {4'd4,  1'b0, 2'd1, 32'h0,         1'b1, 32'hAABB_CCDD},  // R4
    {4'd4,  1'b0, 2'd1, 32'h0,         1'b1, 32'hAABB_CCDD},  // R4 hold
    {4'd4,  1'b0, 2'd0, 32'h0,         1'b1, 32'h0000_0001},  // R4 idx unchanged
    {4'd3,  1'b1, 2'd1, 32'hDEAD_BEEF, 1'b0, 32'h0},          // R3 write while dir=0
    {4'd3,  1'b0, 2'd1, 32'h0,         1'b1, 32'hAABB_CCDD},  // R3 ignored
    {4'd5,  1'b1, 2'd0, 32'hC000_007F, 1'b0, 32'h0},          // R5 idx 127
    {4'd5,  1'b1, 2'd1, 32'h5566_7788, 1'b0, 32'h0},          // R5
    {4'd5,  1'b0, 2'd0, 32'h0,         1'b1, 32'hC000_0000},  // R5 wrapped
    {4'd5,  1'b1, 2'd0, 32'h4000_007F, 1'b0, 32'h0},          // R5
    {4'd5,  1'b0, 2'd1, 32'h0,         1'b1, 32'h5566_7788},  // R5
    {4'd5,  1'b0, 2'd1, 32'h0,         1'b1, 32'h1122_3344},  // R5 word 0 after wrap
    {4'd10, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0},          // R10
    {4'd10, 1'b0, 2'd2, 32'h0,         1'b1, 32'h0000_01FF},  // R10 9 bits kept
    {4'd2,  1'b1, 2'd0, 32'h0000_0080, 1'b0, 32'h0},          // R2 bit 7 ignored
    {4'd2,  1'b0, 2'd0, 32'h0,         1'b1, 32'h0000_0000}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hacc(input logic we, input logic [1:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic ack);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_wdata = wd;
    #1;
    rd = h_rdata; ack = h_ack;
    @(posedge clk);
    #1;
    h_req = 1'b0; h_we = 1'b0;
  endtask

  task automatic sstart();
    @(negedge clk); s_start = 1'b1;
    @(posedge clk); #1; s_start = 1'b0;
  endtask

  task automatic sbyte(input logic we, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_wdata = wd;
    #1; rd = s_rdata;
    @(posedge clk); #1;
    s_req = 1'b0; s_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    logic        ack;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    hacc(1'b0, 2'd0, 32'h0, rd, ack); check("R1 ctrl", rd, 32'h0);
    hacc(1'b0, 2'd2, 32'h0, rd, ack); check("R1 offset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      hacc(VEC[i][67], VEC[i][66:65], VEC[i][64:33], rd, ack);
      check($sformatf("R%0d vec %0d ack", VEC[i][71:68], i), {31'b0, ack}, 32'h1);
      if (VEC[i][32])
        check($sformatf("R%0d vec %0d", VEC[i][71:68], i), rd, VEC[i][31:0]);
    end

    // R9 stall during sequencer transfer, R8 byte writes
    hacc(1'b1, 2'd0, 32'h4000_0001, rd, ack);
    hacc(1'b1, 2'd2, 32'd5, rd, ack);
    sstart();
    s_busy = 1'b1;
    sbyte(1'b1, 8'hA1, b);
    sbyte(1'b1, 8'hA2, b);
    sbyte(1'b1, 8'hA3, b);
    hacc(1'b0, 2'd1, 32'h0, rd, ack);
    check("R9 data stalled", {31'b0, ack}, 32'h0);
    hacc(1'b0, 2'd0, 32'h0, rd, ack);
    check("R9 ctrl ack", {31'b0, ack}, 32'h1);
    check("R9 index held", rd, 32'h4000_0001);
    s_busy = 1'b0;
    hacc(1'b0, 2'd1, 32'h0, rd, ack);
    check("R6 R8 merged word", rd, 32'hA3A2_A1DD);
    hacc(1'b0, 2'd0, 32'h0, rd, ack);
    check("R4 after stall", rd, 32'h4000_0002);

    // R7 start at offset 4, R8 read bytes
    hacc(1'b1, 2'd2, 32'd4, rd, ack);
    sstart();
    s_busy = 1'b1;
    sbyte(1'b0, 8'h00, b); check("R8 byte 4", {24'b0, b}, 32'hDD);
    sbyte(1'b0, 8'h00, b); check("R7 advance byte 5", {24'b0, b}, 32'hA1);
    s_busy = 1'b0;

    // R7 wrap from byte 511
    hacc(1'b1, 2'd2, 32'd511, rd, ack);
    sstart();
    s_busy = 1'b1;
    sbyte(1'b1, 8'h77, b);
    sbyte(1'b0, 8'h00, b); check("R7 wrap to byte 0", {24'b0, b}, 32'h44);
    s_busy = 1'b0;
    hacc(1'b1, 2'd0, 32'h0000_007F, rd, ack);
    hacc(1'b0, 2'd1, 32'h0, rd, ack);
    check("R6 top lane", rd, 32'h7766_7788);

    done = 1'b1;
    finish_run();
  end
endmodule